// File: doc/BRIEF.md
# Streaming Vector Load/Store Address Unit

This unit is the side path of a vector processor that moves one operand to or from memory alongside an arithmetic instruction. It keeps three 32-bit stream pointers: an output pointer used by stores and two input pointers used by loads. A 3-bit selector in the instruction picks the access: a single-word or double-word store through the output pointer, or a single-word or double-word load through either input pointer. After the memory side accepts the request, the pointer in use advances by the access size.

Store data comes from a register-file read port. Load data goes back through a register-file write port when the memory response arrives. A double-word access works on an even/odd register pair. The three pointers can also be read and written through a small control-register port, so software can set up a stream and read back where it stopped. The unit handles one operation at a time. It shows this by dropping `opReady` until the operation has finished.

Top module: `stream_ls_unit`

## Requirements
- R1: The selector is {instruction bit 10, instruction bit 9, instruction bit 6}, presented as `lsHi` = bits [10:9] and `lsLo` = bit 6. The selectors map as follows: 1 is a 32-bit store through the output pointer; 3 is a 64-bit store through the output pointer; 4 and 5 are 32-bit loads through input pointer 0 and input pointer 1; 6 and 7 are 64-bit loads through input pointer 0 and input pointer 1. `memWrite` is 1 for stores and `memDouble` is 1 for 64-bit accesses. `memAddr` is the value the selected pointer held when the operation was accepted.
- R2: The pointer used by an access increases by 4 for a 32-bit access and by 8 for a 64-bit access. The increment happens in the cycle in which `memValid` and `memReady` are both high, and at no other time. Addition wraps modulo 2^32.
- R3: For a 64-bit access, `rfRdIdx` and `rfWrIdx` equal `opReg` with bit 0 cleared. For a 32-bit access they equal `opReg`.
- R4: For a 32-bit store, `memWData[31:0]` is `rfRdData[31:0]` sampled at acceptance and `memWData[63:32]` is zero. For a 64-bit store, `memWData` is all of `rfRdData`.
- R5: After a load request is accepted, the unit waits for `memRspValid`. In that cycle `rfWe` is high for exactly one cycle. `rfWrData` is `memRspData` for a 64-bit load, or `memRspData[31:0]` zero-extended for a 32-bit load. `rfWrDouble` marks the 64-bit case.
- R6: Selector 0 (bits 10, 9 and 6 all zero) is taken as "no parallel access". It makes no memory request, no register write and no error, leaves every pointer unchanged, and `opReady` stays high.
- R7: Selector 2 is illegal. One cycle after acceptance it raises `errPulse` for a single cycle. It makes no memory request and leaves every pointer unchanged.
- R8: Control-register addresses 0x4000, 0x4001 and 0x4002 read and write input pointer 0, input pointer 1 and the output pointer. `crRdData` is combinational from `crAddr`. Any other address reads as zero, and a write to it has no effect.
- R9: A control-register write to a pointer in the same cycle as that pointer's increment wins: the pointer takes the written value.
- R10: While `memValid` is high and `memReady` is low, `memValid`, `memAddr`, `memWrite`, `memDouble` and `memWData` hold steady. `opReady` is low from acceptance of an access until that access completes.
- R11: After reset, all pointers are zero, `memValid`, `rfWe` and `errPulse` are low, and `opReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Instruction with parallel load/store field is presented |
| opReady | output | 1 | Unit idle and able to take an instruction |
| lsHi | input | 2 | Instruction bits [10:9], upper selector bits |
| lsLo | input | 1 | Instruction bit 6, low selector bit |
| opReg | input | 5 | Register index named by the instruction |
| errPulse | output | 1 | One-cycle flag for an illegal selector |
| rfRdIdx | output | 5 | Register-file read index for store data |
| rfRdData | input | 64 | Register-file read data (pair, or word in [31:0]) |
| rfWe | output | 1 | Register-file write enable for load data |
| rfWrIdx | output | 5 | Register-file write index |
| rfWrDouble | output | 1 | Write covers a register pair |
| rfWrData | output | 64 | Register-file write data |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory request accepted |
| memWrite | output | 1 | Request is a store |
| memDouble | output | 1 | Request is 64 bits wide |
| memAddr | output | 32 | Request byte address |
| memWData | output | 64 | Store data |
| memRspValid | input | 1 | Load response valid |
| memRspData | input | 64 | Load response data |
| crWrEn | input | 1 | Control-register write strobe |
| crAddr | input | 16 | Control-register address |
| crWrData | input | 32 | Control-register write data |
| crRdData | output | 32 | Control-register read data |

## Verification
The selectors are driven in a seeded random mix with odd and even register indices, random memory stalls and random response delays. Odd indices separate pair indexing from single indexing, and the stalls show whether the pointer moves at acceptance or only at the handshake. Directed cases cover the following: each selector once from known pointer values, which ties every selector to its own pointer and step; wrap-around near the top of the address space; selectors 0 and 2, which separate a quiet no-op from the error case; a control-register write that lands in the same cycle as the increment; and reads and writes at an unmapped address.

// File: rtl/stream_pkg.sv
package stream_pkg;

  localparam int NUM_PTR = 3;

  typedef enum logic [1:0] {
    PTR_IN0 = 2'd0,
    PTR_IN1 = 2'd1,
    PTR_OUT = 2'd2
  } ptrSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } lsState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       capture;   // latch address and store data
    logic       bump;      // post-increment the selected pointer
    logic [1:0] ptrIdx;    // pointer in use
    logic       dbl;       // 64-bit access
  } lsStrobe_t;

  // Selector {bit10, bit9, bit6} decode helpers
  function automatic logic selActive(input logic [2:0] sel);
    return sel[2] | sel[0];
  endfunction

  function automatic logic selIllegal(input logic [2:0] sel);
    return sel == 3'd2;
  endfunction

  function automatic logic selStore(input logic [2:0] sel);
    return ~sel[2];
  endfunction

  function automatic logic selDouble(input logic [2:0] sel);
    return sel[1];
  endfunction

  function automatic logic [1:0] selPtr(input logic [2:0] sel);
    if (!sel[2]) return PTR_OUT;
    return sel[0] ? PTR_IN1 : PTR_IN0;
  endfunction

endpackage

// File: rtl/stream_ls_ctrl.sv
module stream_ls_ctrl
  import stream_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  output logic             opReady,
  input  logic [1:0]       lsHi,
  input  logic             lsLo,
  input  logic [REG_W-1:0] opReg,
  output logic             errPulse,
  input  logic             memReady,
  input  logic             memRspValid,
  output logic             memValid,
  output logic             memWrite,
  output logic             memDouble,
  output logic [REG_W-1:0] rfRdIdx,
  output logic             rfWe,
  output logic [REG_W-1:0] rfWrIdx,
  output logic             rfWrDouble,
  output lsStrobe_t        strobe
);

  lsState_e         state;
  logic [2:0]       sel;
  logic             decDbl;
  logic [1:0]       decIdx;
  logic             accept;
  logic [1:0]       curIdx;
  logic             curDbl;
  logic             curStore;
  logic [REG_W-1:0] curReg;
  logic [REG_W-1:0] liveIdx;

  assign sel     = {lsHi, lsLo};
  assign decDbl  = selDouble(sel);
  assign decIdx  = selPtr(sel);
  assign opReady = (state == ST_IDLE);
  assign accept  = opReady && opValid && selActive(sel);
  assign liveIdx = decDbl ? {opReg[REG_W-1:1], 1'b0} : opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curIdx   <= PTR_IN0;
      curDbl   <= 1'b0;
      curStore <= 1'b0;
      curReg   <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_REQ;
            curIdx   <= decIdx;
            curDbl   <= decDbl;
            curStore <= selStore(sel);
            curReg   <= liveIdx;
          end else if (opValid && selIllegal(sel)) begin
            errPulse <= 1'b1;
          end
        end
        ST_REQ: begin
          if (memReady) state <= curStore ? ST_IDLE : ST_RSP;
        end
        ST_RSP: begin
          if (memRspValid) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memValid   = (state == ST_REQ);
  assign memWrite   = curStore;
  assign memDouble  = curDbl;
  assign rfRdIdx    = liveIdx;
  assign rfWe       = (state == ST_RSP) && memRspValid;
  assign rfWrIdx    = curReg;
  assign rfWrDouble = curDbl;

  always_comb begin
    strobe.capture = accept;
    strobe.bump    = memValid && memReady;
    strobe.ptrIdx  = opReady ? decIdx : curIdx;
    strobe.dbl     = opReady ? decDbl : curDbl;
  end

endmodule

// File: rtl/stream_ls_datapath.sv
module stream_ls_datapath
  import stream_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          WORD_W  = 32,
  parameter int          CRA_W   = 16,
  parameter logic [15:0] CR_BASE = 16'h4000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  lsStrobe_t                      strobe,
  input  logic                           crWrEn,
  input  logic [CRA_W-1:0]               crAddr,
  input  logic [ADDR_W-1:0]              crWrData,
  output logic [ADDR_W-1:0]              crRdData,
  input  logic [2*WORD_W-1:0]            rfRdData,
  input  logic [2*WORD_W-1:0]            memRspData,
  output logic [2*WORD_W-1:0]            rfWrData,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [2*WORD_W-1:0]            memWData,
  output logic [NUM_PTR-1:0][ADDR_W-1:0] ptrVec
);

  localparam int          DW       = 2 * WORD_W;
  localparam logic [ADDR_W-1:0] STEP_S = ADDR_W'(WORD_W / 8);
  localparam logic [ADDR_W-1:0] STEP_D = ADDR_W'(DW / 8);

  logic [ADDR_W-1:0] addrHold;
  logic [DW-1:0]     dataHold;
  logic [ADDR_W-1:0] step;

  assign step = strobe.dbl ? STEP_D : STEP_S;

  for (genvar g = 0; g < NUM_PTR; g++) begin : gPtr
    logic crHit;
    logic bumpHit;
    assign crHit   = crWrEn && (crAddr == CR_BASE + CRA_W'(g));
    assign bumpHit = strobe.bump && (strobe.ptrIdx == 2'(g));
    always_ff @(posedge clk) begin
      if (!rstN)        ptrVec[g] <= '0;
      else if (crHit)   ptrVec[g] <= crWrData;
      else if (bumpHit) ptrVec[g] <= ptrVec[g] + step;
    end
  end

  always_comb begin
    crRdData = '0;
    for (int k = 0; k < NUM_PTR; k++) begin
      if (crAddr == CR_BASE + CRA_W'(k)) crRdData = ptrVec[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHold <= '0;
      dataHold <= '0;
    end else if (strobe.capture) begin
      addrHold <= ptrVec[strobe.ptrIdx];
      dataHold <= strobe.dbl ? rfRdData : {{WORD_W{1'b0}}, rfRdData[WORD_W-1:0]};
    end
  end

  assign memAddr  = addrHold;
  assign memWData = dataHold;
  assign rfWrData = strobe.dbl ? memRspData : {{WORD_W{1'b0}}, memRspData[WORD_W-1:0]};

endmodule

// File: rtl/stream_ls_unit.sv
module stream_ls_unit
  import stream_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          WORD_W  = 32,
  parameter int          REG_W   = 5,
  parameter int          CRA_W   = 16,
  parameter logic [15:0] CR_BASE = 16'h4000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  output logic                opReady,
  input  logic [1:0]          lsHi,
  input  logic                lsLo,
  input  logic [REG_W-1:0]    opReg,
  output logic                errPulse,
  output logic [REG_W-1:0]    rfRdIdx,
  input  logic [2*WORD_W-1:0] rfRdData,
  output logic                rfWe,
  output logic [REG_W-1:0]    rfWrIdx,
  output logic                rfWrDouble,
  output logic [2*WORD_W-1:0] rfWrData,
  output logic                memValid,
  input  logic                memReady,
  output logic                memWrite,
  output logic                memDouble,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*WORD_W-1:0] memWData,
  input  logic                memRspValid,
  input  logic [2*WORD_W-1:0] memRspData,
  input  logic                crWrEn,
  input  logic [CRA_W-1:0]    crAddr,
  input  logic [ADDR_W-1:0]   crWrData,
  output logic [ADDR_W-1:0]   crRdData
);

  lsStrobe_t                      strobe;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrVec;

  stream_ls_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .lsHi(lsHi), .lsLo(lsLo), .opReg(opReg), .errPulse(errPulse),
    .memReady(memReady), .memRspValid(memRspValid), .memValid(memValid),
    .memWrite(memWrite), .memDouble(memDouble), .rfRdIdx(rfRdIdx),
    .rfWe(rfWe), .rfWrIdx(rfWrIdx), .rfWrDouble(rfWrDouble), .strobe(strobe)
  );

  stream_ls_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CRA_W(CRA_W), .CR_BASE(CR_BASE)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .crWrEn(crWrEn), .crAddr(crAddr),
    .crWrData(crWrData), .crRdData(crRdData), .rfRdData(rfRdData),
    .memRspData(memRspData), .rfWrData(rfWrData), .memAddr(memAddr),
    .memWData(memWData), .ptrVec(ptrVec)
  );

endmodule

// File: rtl/stream_ls_checker.sv
module stream_ls_checker
  import stream_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          WORD_W  = 32,
  parameter int          CRA_W   = 16,
  parameter logic [15:0] CR_BASE = 16'h4000
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           opValid,
  input logic                           opReady,
  input logic                           errPulse,
  input logic                           rfWe,
  input logic                           memValid,
  input logic                           memReady,
  input logic                           memWrite,
  input logic                           memDouble,
  input logic [ADDR_W-1:0]              memAddr,
  input logic [2*WORD_W-1:0]            memWData,
  input logic                           crWrEn,
  input logic [CRA_W-1:0]               crAddr,
  input logic [ADDR_W-1:0]              crWrData,
  input logic [1:0]                     curIdx,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] ptrVec
);

  logic              crHitSel;
  logic              lastBump;
  logic [1:0]        lastIdx;
  logic [ADDR_W-1:0] lastPtr;
  logic [ADDR_W-1:0] lastStep;
  logic              lastCrHit;
  logic [1:0]        lastCrIdx;
  logic [ADDR_W-1:0] lastCrData;
  logic              inRange;

  assign crHitSel = crWrEn && (crAddr == CR_BASE + CRA_W'(curIdx));
  assign inRange  = (crAddr >= CR_BASE) && (crAddr < CR_BASE + CRA_W'(NUM_PTR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastBump   <= 1'b0;
      lastIdx    <= '0;
      lastPtr    <= '0;
      lastStep   <= '0;
      lastCrHit  <= 1'b0;
      lastCrIdx  <= '0;
      lastCrData <= '0;
    end else begin
      lastBump   <= memValid && memReady && !crHitSel;
      lastIdx    <= curIdx;
      lastPtr    <= ptrVec[curIdx];
      lastStep   <= memDouble ? ADDR_W'(8) : ADDR_W'(4);
      lastCrHit  <= crWrEn && inRange;
      lastCrIdx  <= 2'(crAddr - CR_BASE);
      lastCrData <= crWrData;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWrite)
      && $stable(memDouble) && $stable(memWData)) else $error("request changed"); // R10

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !opReady) else $error("ready while busy"); // R10

  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(opValid && opReady) && !memValid) else $error("stray error"); // R7

  AST_POST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    lastBump |-> ptrVec[lastIdx] == lastPtr + lastStep) else $error("bad step"); // R2

  AST_CR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    lastCrHit |-> ptrVec[lastCrIdx] == lastCrData) else $error("cr write lost"); // R9

  AST_RF_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> !opReady && !memValid) else $error("write outside wait"); // R5

endmodule

bind stream_ls_unit stream_ls_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CRA_W(CRA_W), .CR_BASE(CR_BASE)
) uChk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
  .errPulse(errPulse), .rfWe(rfWe), .memValid(memValid), .memReady(memReady),
  .memWrite(memWrite), .memDouble(memDouble), .memAddr(memAddr),
  .memWData(memWData), .crWrEn(crWrEn), .crAddr(crAddr), .crWrData(crWrData),
  .curIdx(strobe.ptrIdx), .ptrVec(ptrVec)
);

// File: tb/tb_stream_ls_unit.sv
`timescale 1ns/1ps
module tb_stream_ls_unit;

  logic        clk = 0;
  logic        rstN = 0;
  logic        opValid = 0;
  logic        opReady;
  logic [1:0]  lsHi = 0;
  logic        lsLo = 0;
  logic [4:0]  opReg = 0;
  logic        errPulse;
  logic [4:0]  rfRdIdx;
  logic [63:0] rfRdData = 0;
  logic        rfWe;
  logic [4:0]  rfWrIdx;
  logic        rfWrDouble;
  logic [63:0] rfWrData;
  logic        memValid;
  logic        memReady = 0;
  logic        memWrite;
  logic        memDouble;
  logic [31:0] memAddr;
  logic [63:0] memWData;
  logic        memRspValid = 0;
  logic [63:0] memRspData = 0;
  logic        crWrEn = 0;
  logic [15:0] crAddr = 0;
  logic [31:0] crWrData = 0;
  logic [31:0] crRdData;

  int nChecks = 0;
  int nErr = 0;
  logic [31:0] mp [3];

  stream_ls_unit dut (.*);

  always #10 clk = ~clk;

  function automatic logic [63:0] rspOf(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, a + 32'h1111_0001};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  task automatic ptrChk(input string tag);
    for (int k = 0; k < 3; k++) begin
      crAddr = 16'h4000 + 16'(k);
      #1 chk(tag, {32'b0, crRdData}, {32'b0, mp[k]});
    end
  endtask

  task automatic crWrite(input logic [15:0] a, input logic [31:0] v);
    @(negedge clk);
    crWrEn = 1; crAddr = a; crWrData = v;
    @(posedge clk);
    @(negedge clk);
    crWrEn = 0;
    if (a >= 16'h4000 && a <= 16'h4002) mp[a - 16'h4000] = v;
  endtask

  task automatic runOp(input logic [2:0] sel, input logic [4:0] rg, input logic [63:0] rd,
                       input int stalls, input int dly, input bit prio, input logic [31:0] pv);
    bit acc, st, dbl;
    int idx;
    logic [4:0] ri;
    logic [31:0] ea;
    logic [63:0] ew, rsp;
    acc = sel[2] | sel[0];
    st  = !sel[2];
    dbl = sel[1];
    idx = st ? 2 : (sel[0] ? 1 : 0);
    ri  = dbl ? {rg[4:1], 1'b0} : rg;
    ea  = mp[idx];
    ew  = dbl ? rd : {32'b0, rd[31:0]};
    @(negedge clk);
    opValid = 1; lsHi = sel[2:1]; lsLo = sel[0]; opReg = rg; rfRdData = rd;
    #1 chk("R10 ready when idle", {63'b0, opReady}, 64'd1);
    if (acc) chk("R3 read index", {59'b0, rfRdIdx}, {59'b0, ri});
    @(posedge clk);
    @(negedge clk);
    opValid = 0;
    #1;
    if (!acc) begin
      chk("R7 error pulse", {63'b0, errPulse}, {63'b0, sel == 3'd2});
      chk("R6 no request", {63'b0, memValid}, 64'd0);
      chk("R6 ready", {63'b0, opReady}, 64'd1);
      @(negedge clk);
      #1 chk("R7 pulse ends", {63'b0, errPulse}, 64'd0);
      ptrChk("R6 R7 pointers kept");
      return;
    end
    for (int s = 0; s <= stalls; s++) begin
      if (s > 0) begin @(negedge clk); #1; end
      chk("R10 valid held", {63'b0, memValid}, 64'd1);
      chk("R10 busy", {63'b0, opReady}, 64'd0);
      chk("R1 address", {32'b0, memAddr}, {32'b0, ea});
      chk("R1 write flag", {63'b0, memWrite}, {63'b0, st});
      chk("R1 double flag", {63'b0, memDouble}, {63'b0, dbl});
      if (st) chk("R4 store data", memWData, ew);
      if (s < stalls) begin
        memReady = 0;
        @(posedge clk);
        crAddr = 16'h4000 + 16'(idx);
        #1 chk("R2 no step while stalled", {32'b0, crRdData}, {32'b0, mp[idx]});
      end
    end
    memReady = 1;
    if (prio) begin crWrEn = 1; crAddr = 16'h4000 + 16'(idx); crWrData = pv; end
    @(posedge clk);
    @(negedge clk);
    memReady = 0; crWrEn = 0;
    if (prio) mp[idx] = pv;
    else mp[idx] = mp[idx] + (dbl ? 32'd8 : 32'd4);
    ptrChk(prio ? "R9 cr write wins" : "R2 post increment");
    if (!st) begin
      rsp = rspOf(ea);
      for (int d = 0; d < dly; d++) begin
        #1 chk("R5 no early write", {63'b0, rfWe}, 64'd0);
        @(negedge clk);
      end
      memRspValid = 1; memRspData = rsp;
      #1 chk("R5 write enable", {63'b0, rfWe}, 64'd1);
      chk("R3 write index", {59'b0, rfWrIdx}, {59'b0, ri});
      chk("R5 pair flag", {63'b0, rfWrDouble}, {63'b0, dbl});
      chk("R5 write data", rfWrData, dbl ? rsp : {32'b0, rsp[31:0]});
      @(posedge clk);
      @(negedge clk);
      memRspValid = 0;
      #1 chk("R5 single write", {63'b0, rfWe}, 64'd0);
    end else begin
      #1 chk("R5 no write on store", {63'b0, rfWe}, 64'd0);
    end
    chk("R10 ready after op", {63'b0, opReady}, 64'd1);
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1337));
    for (int k = 0; k < 3; k++) mp[k] = 0;
    @(negedge clk);
    #1 chk("R11 reset valid", {63'b0, memValid}, 64'd0);
    chk("R11 reset ready", {63'b0, opReady}, 64'd1);
    repeat (2) @(negedge clk);
    rstN = 1;
    #1 chk("R11 reset error", {63'b0, errPulse}, 64'd0);
    chk("R11 reset rf write", {63'b0, rfWe}, 64'd0);
    ptrChk("R11 reset pointers");

    // Directed: each pointer set, each selector once
    crWrite(16'h4000, 32'h0000_1000);
    crWrite(16'h4001, 32'h0000_2000);
    crWrite(16'h4002, 32'h0000_3000);
    ptrChk("R8 pointer write");
    crAddr = 16'h4003;
    #1 chk("R8 unmapped read", {32'b0, crRdData}, 64'd0);
    crWrite(16'h3FFF, 32'hDEAD_BEEF);
    crWrite(16'h4003, 32'hDEAD_BEEF);
    ptrChk("R8 unmapped write ignored");

    runOp(3'd1, 5'd7, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 0);
    runOp(3'd3, 5'd7, 64'h1122_3344_5566_7788, 2, 0, 0, 0);
    runOp(3'd4, 5'd3, 64'h0, 1, 0, 0, 0);
    runOp(3'd5, 5'd9, 64'h0, 0, 2, 0, 0);
    runOp(3'd6, 5'd11, 64'h0, 0, 1, 0, 0);
    runOp(3'd7, 5'd4, 64'h0, 3, 3, 0, 0);
    runOp(3'd0, 5'd1, 64'h0, 0, 0, 0, 0);
    runOp(3'd2, 5'd1, 64'h0, 0, 0, 0, 0);
    runOp(3'd6, 5'd2, 64'h0, 1, 0, 1, 32'h0000_ABC0);
    runOp(3'd1, 5'd2, 64'hFFFF_FFFF_0000_0001, 0, 0, 1, 32'h0000_5550);

    // Wrap-around
    crWrite(16'h4002, 32'hFFFF_FFFC);
    runOp(3'd3, 5'd13, 64'hCAFE_F00D_0BAD_BEEF, 0, 0, 0, 0);
    chk("R2 wrap", {32'b0, mp[2]}, 64'h4);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 8 == 0)
        crWrite(16'h4000 + 16'($urandom % 4), $urandom & 32'hFFFF_FFF8);
      runOp(3'($urandom % 8), 5'($urandom % 32), {$urandom, $urandom},
            $urandom % 4, $urandom % 4, ($urandom % 10) == 0, $urandom);
    end

    finishRun();
  end

endmodule